// File: doc/BRIEF.md
# Interruptible Vector Dot-Product Sequencer

This block walks two vectors held in a word-addressed memory, multiplies their elements pair by pair and sums the products into a wide accumulator. A command names an operation and one of several parameter sets. Each set holds the two base addresses, the address step between elements, and the element count. After a fixed setup phase the sequencer spends a fixed number of clocks on each element, so the run time is exact and linear in the count whenever memory accepts each read at once.

Both vector forms can be parked between elements by an interrupt request. When parked, the sequencer stores the remaining count and the next addresses back into the set it was started from, raises a flag and goes idle with the partial sum still in the accumulator. A later command with the resume bit set continues from the next element. A third operation evaluates a polynomial by Horner's rule, reading coefficients and using a constant given with the command.

The command port is a valid/ready handshake: `cmd_ready` is high only while idle, and a command is taken on a clock edge where both are high. The memory read port is also valid/ready, and its data is returned in the cycle of the handshake. While `rd_valid` is high and `rd_ready` is low, the sequencer holds the request and its address, and its schedule stops for that cycle.

Top module: `vdp_seq`

## Requirements
- R1: Operation code 0 (code 3 behaves the same) is a single-word dot product. With no read stalls `busy` is high for exactly 10 + 8*N cycles, and the accumulator then holds the signed sum of products of the N element pairs.
- R2: Operation code 1 is a two-word dot product. Each operand is 32 bits: its upper word is at the element address and its lower word at the element address + 1. With no stalls `busy` lasts exactly 10 + 16*N cycles.
- R3: Element i of the first vector is read at base_a + i*step and element i of the second vector at base_b + i*step. All addresses wrap modulo 2^AW.
- R4: A vector command with a count of zero keeps `busy` high for 10 cycles, makes no read, and leaves the accumulator at zero.
- R5: Operation code 2 evaluates a polynomial with x = `cmd_x`. The coefficient with the highest degree is read first, at base_a, and the rest follow at the step. For N >= 1 `busy` lasts 7*N - 2 cycles. For N = 0 it lasts 1 cycle and the result is zero.
- R6: If `irq` is high at the end of a vector element that is not the last, that element still completes. The set used then takes count = remaining elements and addresses = those of the next element, while its step is unchanged. `interrupted` rises, `busy` falls, and `done` does not pulse.
- R7: A command with `cmd_resume` = 1 keeps the accumulator. It runs the 10-cycle setup and then the remaining elements, so the final result equals that of a run without interruption.
- R8: The polynomial operation ignores `irq` and always runs to completion.
- R9: While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_addr` hold. Each such cycle adds exactly one cycle to the run time.
- R10: After reset the block is idle with `cmd_ready` high and `busy`, `done`, `interrupted` and the accumulator at zero. `done` pulses for one cycle, the first idle cycle after a completed run. `interrupted` clears when the next command is accepted.
- R11: `cmd_sel` picks the parameter set. A park writes only that set, and the other sets keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high (idle) |
| cmd_op | input | 2 | 0 single dot, 1 double dot, 2 polynomial, 3 as 0 |
| cmd_sel | input | SW | Parameter set select |
| cmd_resume | input | 1 | Keep accumulator and continue |
| cmd_x | input | W | Polynomial argument |
| irq | input | 1 | Park request, seen at element ends |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| interrupted | output | 1 | Last run was parked |
| acc | output | ACCW | Accumulator |
| rd_valid | output | 1 | Read request |
| rd_ready | input | 1 | Memory takes the request, data valid |
| rd_addr | output | AW | Read word address |
| rd_data | input | W | Read data, valid with the handshake |
| pw_en | input | 1 | Write a parameter set |
| pw_sel | input | SW | Set to write |
| pw_addr_a | input | AW | First vector / coefficient base |
| pw_addr_b | input | AW | Second vector base |
| pw_stride | input | AW | Address step per element |
| pw_count | input | CW | Element count |
| pr_sel | input | SW | Set to observe |
| pr_addr_a | output | AW | Observed first base |
| pr_addr_b | output | AW | Observed second base |
| pr_stride | output | AW | Observed step |
| pr_count | output | CW | Observed count |

## Verification
The bench builds the block with four parameter sets, 16-bit words and addresses, an 8-bit count and an 80-bit accumulator, with a 256-word memory model behind the read port. Four sets let a park into one set be checked against a neighbour that must stay untouched. The 80-bit accumulator holds sums of 32-bit by 32-bit products with headroom, so a plain 64-bit reference sum in the bench matches the result bit for bit. Run times are counted cycle by cycle, both with memory always ready and with a periodic stall pattern, and parks are placed in the middle of known elements so the written-back count and addresses are known in advance.

// File: rtl/vdp_pkg.sv
package vdp_pkg;
  typedef enum logic [1:0] {
    OP_DOT1 = 2'd0,
    OP_DOT2 = 2'd1,
    OP_POLY = 2'd2,
    OP_RSVD = 2'd3
  } vdp_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RUN   = 2'd2
  } vdp_st_e;

  localparam int unsigned SETUP_CYC = 10;
endpackage

// File: rtl/vdp_bank.sv
module vdp_bank #(
  parameter int NSETS = 4,
  parameter int AW    = 16,
  parameter int CW    = 12,
  parameter int SW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pw_en,
  input  logic [SW-1:0] pw_sel,
  input  logic [AW-1:0] pw_a,
  input  logic [AW-1:0] pw_b,
  input  logic [AW-1:0] pw_s,
  input  logic [CW-1:0] pw_c,
  input  logic          wb_en,
  input  logic [SW-1:0] wb_sel,
  input  logic [AW-1:0] wb_a,
  input  logic [AW-1:0] wb_b,
  input  logic [CW-1:0] wb_c,
  input  logic [SW-1:0] r0_sel,
  output logic [AW-1:0] r0_a,
  output logic [AW-1:0] r0_b,
  output logic [AW-1:0] r0_s,
  output logic [CW-1:0] r0_c,
  input  logic [SW-1:0] r1_sel,
  output logic [AW-1:0] r1_a,
  output logic [AW-1:0] r1_b,
  output logic [AW-1:0] r1_s,
  output logic [CW-1:0] r1_c
);
  logic [AW-1:0] base_a_q [NSETS];
  logic [AW-1:0] base_b_q [NSETS];
  logic [AW-1:0] step_q   [NSETS];
  logic [CW-1:0] cnt_q    [NSETS];

  // park writeback wins over a load aimed at the same set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSETS; i++) begin
        base_a_q[i] <= '0;
        base_b_q[i] <= '0;
        step_q[i]   <= '0;
        cnt_q[i]    <= '0;
      end
    end else begin
      for (int i = 0; i < NSETS; i++) begin
        if (wb_en && wb_sel == SW'(i)) begin
          base_a_q[i] <= wb_a;
          base_b_q[i] <= wb_b;
          cnt_q[i]    <= wb_c;
        end else if (pw_en && pw_sel == SW'(i)) begin
          base_a_q[i] <= pw_a;
          base_b_q[i] <= pw_b;
          step_q[i]   <= pw_s;
          cnt_q[i]    <= pw_c;
        end
      end
    end
  end

  assign r0_a = base_a_q[r0_sel];
  assign r0_b = base_b_q[r0_sel];
  assign r0_s = step_q[r0_sel];
  assign r0_c = cnt_q[r0_sel];
  assign r1_a = base_a_q[r1_sel];
  assign r1_b = base_b_q[r1_sel];
  assign r1_s = step_q[r1_sel];
  assign r1_c = cnt_q[r1_sel];

  // a park leaves the remaining count in the chosen set
  assert_wb_count_saved_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> cnt_q[$past(wb_sel)] == $past(wb_c));
endmodule

// File: rtl/vdp_mac.sv
module vdp_mac #(
  parameter int W    = 16,
  parameter int ACCW = 80
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            ld,
  input  logic            mac,
  input  logic            hrn,
  input  logic [2*W-1:0]  op_a,
  input  logic [2*W-1:0]  op_b,
  input  logic [W-1:0]    x,
  output logic [ACCW-1:0] acc
);
  localparam int OW = 2 * W;
  localparam int PW = 4 * W;

  logic [PW-1:0]   a_w, b_w, prod;
  logic [ACCW-1:0] prod_x, c_x, x_x, acc_q;

  assign a_w    = {{OW{op_a[OW-1]}}, op_a};
  assign b_w    = {{OW{op_b[OW-1]}}, op_b};
  assign prod   = a_w * b_w;
  assign prod_x = {{(ACCW-PW){prod[PW-1]}}, prod};
  assign c_x    = {{(ACCW-OW){op_a[OW-1]}}, op_a};
  assign x_x    = {{(ACCW-W){x[W-1]}}, x};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (clr) acc_q <= '0;
    else if (mac) acc_q <= acc_q + prod_x;
    else if (ld)  acc_q <= c_x;
    else if (hrn) acc_q <= acc_q * x_x + c_x;
  end

  assign acc = acc_q;

  // the controller never requests two accumulator updates at once (R1, R5)
  assert_one_acc_op_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr, ld, mac, hrn}));
endmodule

// File: rtl/vdp_ctrl.sv
module vdp_ctrl
  import vdp_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 16,
  parameter int CW = 12,
  parameter int SW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [1:0]     cmd_op,
  input  logic [SW-1:0]  cmd_sel,
  input  logic           cmd_resume,
  input  logic [W-1:0]   cmd_x,
  input  logic           irq,
  input  logic [AW-1:0]  s_a,
  input  logic [AW-1:0]  s_b,
  input  logic [AW-1:0]  s_s,
  input  logic [CW-1:0]  s_c,
  output logic           rd_valid,
  input  logic           rd_ready,
  output logic [AW-1:0]  rd_addr,
  input  logic [W-1:0]   rd_data,
  output logic           busy,
  output logic           done,
  output logic           interrupted,
  output logic           wb_en,
  output logic [SW-1:0]  wb_sel,
  output logic [AW-1:0]  wb_a,
  output logic [AW-1:0]  wb_b,
  output logic [CW-1:0]  wb_c,
  output logic           m_clr,
  output logic           m_ld,
  output logic           m_mac,
  output logic           m_hrn,
  output logic [2*W-1:0] op_a,
  output logic [2*W-1:0] op_b,
  output logic [W-1:0]   x_q
);
  vdp_st_e       st;
  vdp_op_e       op;
  logic [3:0]    su_cnt, ph, last_ph;
  logic [CW-1:0] rem;
  logic [AW-1:0] ca, cb, stp;
  logic [SW-1:0] sel_q;
  logic [2*W-1:0] ra, rb;
  logic          first, done_q, intr_q;
  logic          accept, rd_hit, use_b, hi_w, lo_w, stall, rd_fire;
  logic          elem_end, park;
  logic [2*W-1:0] cap_old, cap_new;

  assign cmd_ready = (st == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign busy      = (st != ST_IDLE);

  // read slots inside one element
  always_comb begin
    rd_hit = 1'b0;
    use_b  = 1'b0;
    hi_w   = 1'b0;
    lo_w   = 1'b0;
    case (op)
      OP_DOT2: begin
        case (ph)
          4'd0: begin rd_hit = 1'b1; hi_w = 1'b1; end
          4'd1: begin rd_hit = 1'b1; lo_w = 1'b1; end
          4'd4: begin rd_hit = 1'b1; use_b = 1'b1; hi_w = 1'b1; end
          4'd5: begin rd_hit = 1'b1; use_b = 1'b1; lo_w = 1'b1; end
          default: ;
        endcase
      end
      OP_POLY: rd_hit = (ph == 4'd0);
      default: begin
        rd_hit = (ph == 4'd0) || (ph == 4'd2);
        use_b  = (ph == 4'd2);
      end
    endcase
  end

  always_comb begin
    case (op)
      OP_DOT2: last_ph = 4'd15;
      OP_POLY: last_ph = first ? 4'd4 : 4'd6;
      default: last_ph = 4'd7;
    endcase
  end

  assign rd_valid = (st == ST_RUN) && rd_hit;
  assign rd_addr  = (use_b ? cb : ca) + AW'(lo_w);
  assign stall    = rd_valid && !rd_ready;
  assign rd_fire  = rd_valid && rd_ready;
  assign elem_end = (st == ST_RUN) && (ph == last_ph);
  assign park     = irq && (op != OP_POLY);

  assign cap_old = use_b ? rb : ra;
  always_comb begin
    if (hi_w)      cap_new = {rd_data, cap_old[W-1:0]};
    else if (lo_w) cap_new = {cap_old[2*W-1:W], rd_data};
    else           cap_new = {{W{rd_data[W-1]}}, rd_data};
  end

  assign m_clr = accept && !cmd_resume;
  assign m_mac = elem_end && (op != OP_POLY);
  assign m_ld  = elem_end && (op == OP_POLY) && first;
  assign m_hrn = elem_end && (op == OP_POLY) && !first;

  assign wb_en  = elem_end && (rem != CW'(1)) && park;
  assign wb_sel = sel_q;
  assign wb_a   = ca + stp;
  assign wb_b   = cb + stp;
  assign wb_c   = rem - CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; op <= OP_DOT1; su_cnt <= '0; ph <= '0; rem <= '0;
      ca <= '0; cb <= '0; stp <= '0; sel_q <= '0; ra <= '0; rb <= '0;
      x_q <= '0; first <= 1'b0; done_q <= 1'b0; intr_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          ca     <= s_a;
          cb     <= s_b;
          stp    <= s_s;
          rem    <= s_c;
          op     <= (cmd_op == OP_RSVD) ? OP_DOT1 : vdp_op_e'(cmd_op);
          sel_q  <= cmd_sel;
          x_q    <= cmd_x;
          first  <= 1'b1;
          intr_q <= 1'b0;
          ph     <= '0;
          if (cmd_op == OP_POLY) begin
            su_cnt <= 4'd1;
            st     <= (s_c != '0) ? ST_RUN : ST_SETUP;
          end else begin
            su_cnt <= 4'(SETUP_CYC);
            st     <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (su_cnt == 4'd1) begin
            ph <= '0;
            if (rem == '0) begin
              st     <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              st <= ST_RUN;
            end
          end else begin
            su_cnt <= su_cnt - 4'd1;
          end
        end
        ST_RUN: if (!stall) begin
          if (rd_fire) begin
            if (use_b) rb <= cap_new;
            else       ra <= cap_new;
          end
          if (elem_end) begin
            ca    <= ca + stp;
            cb    <= cb + stp;
            rem   <= rem - CW'(1);
            first <= 1'b0;
            ph    <= '0;
            if (rem == CW'(1)) begin
              st     <= ST_IDLE;
              done_q <= 1'b1;
            end else if (park) begin
              st     <= ST_IDLE;
              intr_q <= 1'b1;
            end
          end else begin
            ph <= ph + 4'd1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign done        = done_q;
  assign interrupted = intr_q;
  assign op_a        = ra;
  assign op_b        = rb;

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
  assert_accept_goes_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);
  assert_fall_has_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || interrupted));
  assert_park_needs_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(interrupted) |-> $past(irq));
  assert_park_no_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !interrupted);
  assert_setup_no_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op != 2'd2) |=> !rd_valid);
endmodule

// File: rtl/vdp_seq.sv
module vdp_seq #(
  parameter int W     = 16,
  parameter int AW    = 16,
  parameter int CW    = 12,
  parameter int NSETS = 4,
  parameter int ACCW  = 80,
  localparam int SW   = (NSETS > 1) ? $clog2(NSETS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [1:0]      cmd_op,
  input  logic [SW-1:0]   cmd_sel,
  input  logic            cmd_resume,
  input  logic [W-1:0]    cmd_x,
  input  logic            irq,
  output logic            busy,
  output logic            done,
  output logic            interrupted,
  output logic [ACCW-1:0] acc,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [AW-1:0]   rd_addr,
  input  logic [W-1:0]    rd_data,
  input  logic            pw_en,
  input  logic [SW-1:0]   pw_sel,
  input  logic [AW-1:0]   pw_addr_a,
  input  logic [AW-1:0]   pw_addr_b,
  input  logic [AW-1:0]   pw_stride,
  input  logic [CW-1:0]   pw_count,
  input  logic [SW-1:0]   pr_sel,
  output logic [AW-1:0]   pr_addr_a,
  output logic [AW-1:0]   pr_addr_b,
  output logic [AW-1:0]   pr_stride,
  output logic [CW-1:0]   pr_count
);
  logic [AW-1:0]  s_a, s_b, s_s, wb_a, wb_b;
  logic [CW-1:0]  s_c, wb_c;
  logic [SW-1:0]  wb_sel;
  logic           wb_en, m_clr, m_ld, m_mac, m_hrn;
  logic [2*W-1:0] op_a, op_b;
  logic [W-1:0]   x_q;

  vdp_bank #(.NSETS(NSETS), .AW(AW), .CW(CW), .SW(SW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .pw_en(pw_en), .pw_sel(pw_sel), .pw_a(pw_addr_a), .pw_b(pw_addr_b),
    .pw_s(pw_stride), .pw_c(pw_count),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_a(wb_a), .wb_b(wb_b), .wb_c(wb_c),
    .r0_sel(cmd_sel), .r0_a(s_a), .r0_b(s_b), .r0_s(s_s), .r0_c(s_c),
    .r1_sel(pr_sel), .r1_a(pr_addr_a), .r1_b(pr_addr_b), .r1_s(pr_stride),
    .r1_c(pr_count)
  );

  vdp_ctrl #(.W(W), .AW(AW), .CW(CW), .SW(SW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_sel(cmd_sel), .cmd_resume(cmd_resume), .cmd_x(cmd_x), .irq(irq),
    .s_a(s_a), .s_b(s_b), .s_s(s_s), .s_c(s_c),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .done(done), .interrupted(interrupted),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_a(wb_a), .wb_b(wb_b), .wb_c(wb_c),
    .m_clr(m_clr), .m_ld(m_ld), .m_mac(m_mac), .m_hrn(m_hrn),
    .op_a(op_a), .op_b(op_b), .x_q(x_q)
  );

  vdp_mac #(.W(W), .ACCW(ACCW)) u_mac (
    .clk(clk), .rst_n(rst_n),
    .clr(m_clr), .ld(m_ld), .mac(m_mac), .hrn(m_hrn),
    .op_a(op_a), .op_b(op_b), .x(x_q), .acc(acc)
  );
endmodule

// File: tb/sim_vdp_seq.sv
module sim_vdp_seq;
  localparam int W = 16, AW = 16, CW = 8, NS = 4, ACCW = 80, SW = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cmd_valid, cmd_ready, cmd_resume, irq, busy, done, interrupted;
  logic [1:0] cmd_op;
  logic [SW-1:0] cmd_sel, pw_sel, pr_sel;
  logic [W-1:0] cmd_x, rd_data;
  logic [ACCW-1:0] acc;
  logic rd_valid, rd_ready, pw_en;
  logic [AW-1:0] rd_addr, pw_addr_a, pw_addr_b, pw_stride, pr_addr_a, pr_addr_b, pr_stride;
  logic [CW-1:0] pw_count, pr_count;
  logic [W-1:0] mem [256];

  assign rd_data = mem[rd_addr[7:0]];

  vdp_seq #(.W(W), .AW(AW), .CW(CW), .NSETS(NS), .ACCW(ACCW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_sel(cmd_sel), .cmd_resume(cmd_resume), .cmd_x(cmd_x),
    .irq(irq), .busy(busy), .done(done), .interrupted(interrupted), .acc(acc),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .pw_en(pw_en), .pw_sel(pw_sel), .pw_addr_a(pw_addr_a), .pw_addr_b(pw_addr_b),
    .pw_stride(pw_stride), .pw_count(pw_count), .pr_sel(pr_sel),
    .pr_addr_a(pr_addr_a), .pr_addr_b(pr_addr_b), .pr_stride(pr_stride),
    .pr_count(pr_count)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [ACCW-1:0] ext80(input longint e);
    return {{(ACCW-64){e[63]}}, e};
  endfunction

  function automatic longint opv(input bit dbl, input int ad);
    if (dbl) return longint'($signed({mem[ad % 256], mem[(ad + 1) % 256]}));
    return longint'($signed(mem[ad % 256]));
  endfunction

  function automatic longint exp_dot(input bit dbl, input int a, input int b,
                                     input int s, input int n);
    longint sum = 0;
    for (int i = 0; i < n; i++) sum += opv(dbl, a + i * s) * opv(dbl, b + i * s);
    return sum;
  endfunction

  function automatic longint exp_poly(input int a, input int s, input int n, input longint x);
    longint r = 0;
    for (int i = 0; i < n; i++) r = r * x + opv(1'b0, a + i * s);
    return r;
  endfunction

  task automatic load_set(input int sel, input int a, input int b, input int s, input int c);
    @(negedge clk);
    pw_en = 1'b1; pw_sel = SW'(sel); pw_addr_a = AW'(a); pw_addr_b = AW'(b);
    pw_stride = AW'(s); pw_count = CW'(c);
    @(negedge clk);
    pw_en = 1'b0;
  endtask

  task automatic run_cmd(input int op, input int sel, input bit res, input int x,
                         input int irq_at, input bit stall_mode,
                         output int cyc, output int stalls, output bit saw_done);
    bit last_stall = 1'b0;
    logic [AW-1:0] last_addr = '0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_sel = SW'(sel); cmd_resume = res;
    cmd_x = W'(x);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    cyc = 0; stalls = 0;
    @(negedge clk);
    while (busy) begin
      cyc++;
      if (irq_at != 0 && cyc == irq_at) irq = 1'b1;
      if (stall_mode) rd_ready = (cyc % 3) != 0;
      if (last_stall && !(rd_valid && rd_addr == last_addr)) begin
        errors++;
        $display("FAIL R9 held request: actual addr %0d expected %0d", rd_addr, last_addr);
      end
      last_stall = rd_valid && !rd_ready;
      last_addr  = rd_addr;
      if (last_stall) stalls++;
      @(negedge clk);
    end
    saw_done = done;
    rd_ready = 1'b1;
  endtask

  task automatic t_reset();
    chk(!busy && cmd_ready && !done && !interrupted, "R10", "idle after reset",
        {busy, cmd_ready, done, interrupted}, 4'b0100);
    chk(acc == '0, "R10", "acc after reset", longint'(acc[63:0]), 0);
  endtask

  task automatic t_single(input int a, input int b, input int s, input int n, input string req);
    int cyc, st; bit dn;
    load_set(0, a, b, s, n);
    run_cmd(0, 0, 1'b0, 0, 0, 1'b0, cyc, st, dn);
    chk(cyc == 10 + 8 * n, "R1", "single cycles", cyc, 10 + 8 * n);
    chk(acc == ext80(exp_dot(1'b0, a, b, s, n)), req, "single sum",
        longint'(acc[63:0]), exp_dot(1'b0, a, b, s, n));
    chk(dn, "R10", "done pulse", dn, 1);
    @(negedge clk);
    chk(!done, "R10", "done one cycle", done, 0);
  endtask

  task automatic t_double();
    int cyc, st; bit dn;
    load_set(3, 8, 100, 2, 3);
    run_cmd(1, 3, 1'b0, 0, 0, 1'b0, cyc, st, dn);
    chk(cyc == 10 + 16 * 3, "R2", "double cycles", cyc, 58);
    chk(acc == ext80(exp_dot(1'b1, 8, 100, 2, 3)), "R2", "double sum",
        longint'(acc[63:0]), exp_dot(1'b1, 8, 100, 2, 3));
  endtask

  task automatic t_zero();
    int cyc, st; bit dn;
    load_set(1, 5, 9, 1, 0);
    run_cmd(3, 1, 1'b0, 0, 0, 1'b1, cyc, st, dn);
    chk(cyc == 10, "R4", "empty cycles", cyc, 10);
    chk(st == 0, "R4", "empty read stalls", st, 0);
    chk(acc == '0 && dn, "R4", "empty result", longint'(acc[63:0]), 0);
  endtask

  task automatic t_poly(input int n);
    int cyc, st; bit dn;
    load_set(2, 40, 0, 3, n);
    run_cmd(2, 2, 1'b0, -3, 0, 1'b0, cyc, st, dn);
    chk(cyc == ((n == 0) ? 1 : 7 * n - 2), "R5", "poly cycles", cyc,
        (n == 0) ? 1 : 7 * n - 2);
    chk(acc == ext80(exp_poly(40, 3, n, -3)), "R5", "poly value",
        longint'(acc[63:0]), exp_poly(40, 3, n, -3));
  endtask

  task automatic t_poly_irq();
    int cyc, st; bit dn;
    load_set(2, 60, 0, 1, 4);
    run_cmd(2, 2, 1'b0, 2, 1, 1'b0, cyc, st, dn);
    irq = 1'b0;
    chk(cyc == 26 && dn && !interrupted, "R8", "poly ignores irq", cyc, 26);
    chk(acc == ext80(exp_poly(60, 1, 4, 2)), "R8", "poly value with irq",
        longint'(acc[63:0]), exp_poly(60, 1, 4, 2));
  endtask

  task automatic t_park(input bit dbl);
    int cyc, st, n, s, a, b, len, done_el, at; bit dn;
    a = dbl ? 130 : 32; b = dbl ? 170 : 96; s = 2;
    n = dbl ? 4 : 6; len = dbl ? 16 : 8; done_el = dbl ? 2 : 3;
    at = 10 + len * (done_el - 1) + 3;
    load_set(1, a, b, s, n);
    load_set(2, 7, 8, 9, 10);
    run_cmd(dbl ? 1 : 0, 1, 1'b0, 0, at, 1'b0, cyc, st, dn);
    irq = 1'b0;
    chk(cyc == 10 + len * done_el, "R6", "parked cycles", cyc, 10 + len * done_el);
    chk(interrupted && !dn, "R6", "flag set, no done", {interrupted, dn}, 2);
    pr_sel = 2'd1;
    #1;
    chk(pr_count == CW'(n - done_el), "R6", "saved count", pr_count, n - done_el);
    chk(pr_addr_a == AW'(a + done_el * s) && pr_addr_b == AW'(b + done_el * s),
        "R6", "saved addresses", pr_addr_a, a + done_el * s);
    chk(pr_stride == AW'(s), "R6", "step kept", pr_stride, s);
    chk(acc == ext80(exp_dot(dbl, a, b, s, done_el)), "R6", "partial sum",
        longint'(acc[63:0]), exp_dot(dbl, a, b, s, done_el));
    pr_sel = 2'd2;
    #1;
    chk(pr_addr_a == 7 && pr_addr_b == 8 && pr_stride == 9 && pr_count == 10,
        "R11", "other set untouched", pr_count, 10);
    run_cmd(dbl ? 1 : 0, 1, 1'b1, 0, 0, 1'b0, cyc, st, dn);
    chk(cyc == 10 + len * (n - done_el), "R7", "resume cycles", cyc,
        10 + len * (n - done_el));
    chk(acc == ext80(exp_dot(dbl, a, b, s, n)) && dn && !interrupted, "R7",
        "resumed sum", longint'(acc[63:0]), exp_dot(dbl, a, b, s, n));
  endtask

  task automatic t_stall();
    int cyc, st; bit dn;
    load_set(0, 200, 220, 1, 5);
    run_cmd(0, 0, 1'b0, 0, 0, 1'b1, cyc, st, dn);
    chk(st > 0, "R9", "stalls occurred", st, 1);
    chk(cyc == 50 + st, "R9", "stall extends run", cyc, 50 + st);
    chk(acc == ext80(exp_dot(1'b0, 200, 220, 1, 5)), "R9", "sum under stalls",
        longint'(acc[63:0]), exp_dot(1'b0, 200, 220, 1, 5));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = W'((i * 37 + 11) % 101 - 50);
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_sel = '0; cmd_resume = 1'b0;
    cmd_x = '0; irq = 1'b0; rd_ready = 1'b1; pw_en = 1'b0; pw_sel = '0;
    pw_addr_a = '0; pw_addr_b = '0; pw_stride = '0; pw_count = '0; pr_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single(16, 64, 1, 5, "R1");
    t_single(3, 150, 3, 4, "R3");
    t_double();
    t_zero();
    t_poly(4);
    t_poly(1);
    t_poly(0);
    t_poly_irq();
    t_park(1'b0);
    t_park(1'b1);
    t_stall();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule